// File: doc/BRIEF.md
# Phase-Frequency Detector With Lock Indicator

This block sits after the reference and feedback dividers of a frequency synthesizer. It compares the two divided pulse trains on their rising edges. When the reference edge arrives first, it drives an active-low "raise frequency" pulse. When the feedback edge arrives first, it drives an active-low "lower frequency" pulse. The pulse lasts until the other edge arrives, so its length in sampling clocks follows the phase offset between the two trains.

Two status outputs come from the pulses. The activity output is the NAND of the two active-low pulses, so it is high whenever either pulse is active. The lock flag replaces an analog integrating capacitor with a digital qualifier. At every reference edge the qualifier totals the activity of the period just ended. It declares lock after a run of qualifying periods and drops lock as soon as one period falls short. An enable input can silence the pulse outputs and restart lock qualification.

Top module: `pfd_lock_detector`

## Requirements
- R1: A rising edge on `ref_in` sets the raise-frequency flag at the next clock edge. `up_n` then reads 0 while `dn_n` stays 1 until the feedback edge arrives.
- R2: A rising edge on `fb_in` sets the lower-frequency flag at the next clock edge. `dn_n` then reads 0 while `up_n` stays 1 until the reference edge arrives.
- R3: With the two input edges d clocks apart, the leading side's output is low for d+1 clocks and the trailing side's output is low for 1 clock. With coincident edges, both outputs are low for exactly 1 clock.
- R4: Once both flags are set, both clear at the next clock edge. This gives a one-clock coincident reset.
- R5: `activity` equals the NAND of `up_n` and `dn_n` in every cycle.
- R6: Only rising edges act. Holding an input high, or letting it fall, produces no further pulse.
- R7: At each `ref_in` rising edge, the activity cycles counted since the previous such edge are compared with `width_limit`. A count at or below the limit qualifies the period. `locked` goes to 1 at the evaluation of the 16th consecutive qualifying period (`LOCK_PERIODS`). The first evaluation after reset counts as qualifying.
- R8: A period whose activity count exceeds `width_limit` clears `locked` at its evaluation and restarts the run, so 16 new qualifying periods are needed.
- R9: While `out_en` is 0, `up_n` and `dn_n` stay 1, `activity` stays 0, `locked` is 0 and the qualifying run is cleared. After re-enable, 16 qualifying evaluations are needed again.
- R10: After reset, `up_n` = 1, `dn_n` = 1, `activity` = 0 and `locked` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_in | input | 1 | Divided feedback pulse train |
| ref_in | input | 1 | Divided reference pulse train |
| out_en | input | 1 | 1 enables the pulse outputs and lock qualification |
| width_limit | input | WIDTH_BITS | Highest activity count per period that still qualifies |
| up_n | output | 1 | Active-low raise-frequency pulse |
| dn_n | output | 1 | Active-low lower-frequency pulse |
| activity | output | 1 | NAND of `up_n` and `dn_n` |
| locked | output | 1 | Qualified lock flag |

## Verification
With the default of no input synchronizer, a rising edge driven between clock edges sets its flag at the next clock edge. The pulse outputs change in that same cycle, and the coincident reset follows one clock later. The lock decision is registered at the clock edge that samples a reference rise, so it is due in the first cycle of the following period.

The bench drives inputs on falling clock edges and samples one nanosecond after each rising edge. It counts low cycles over whole 12-clock periods. It reads `locked` only at period boundaries, after exactly 15 and exactly 16 evaluations, which pins the qualification count to one period.

// File: rtl/pfd_lock_pkg.sv
`timescale 1ns/1ps
package pfd_lock_pkg;
   // Pending-edge flags of the detector core.
   typedef struct packed {
      logic up;   // reference edge seen, waiting for feedback
      logic dn;   // feedback edge seen, waiting for reference
   } pfd_flags_t;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/pfd_edge_tap.sv
`timescale 1ns/1ps
module pfd_edge_tap #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic rise
);
   logic s;
   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign s = sig;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= sig;
               for (int i = 1; i < int'(SYNC_STAGES); i++) chain[i] <= chain[i-1];
            end
         end
         assign s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= s;
   end

   assign rise = s & ~prev;
endmodule

// File: rtl/pfd_flag_core.sv
`timescale 1ns/1ps
module pfd_flag_core
   import pfd_lock_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_rise,
   input  logic       fb_rise,
   output pfd_flags_t flags
);
   logic both;
   assign both = flags.up & flags.dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (both) begin
         flags <= '0;                      // coincident reset, one clock wide
      end else begin
         if (ref_rise) flags.up <= 1'b1;
         if (fb_rise)  flags.dn <= 1'b1;
      end
   end

   p_up_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_rise && !both) |=> flags.up);
   p_dn_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_rise && !both) |=> flags.dn);
   p_joint_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.up && flags.dn) |=> (!flags.up && !flags.dn));
   p_no_spurious_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_rise && !flags.up) |=> !flags.up);
endmodule

// File: rtl/pfd_lock_qual.sv
`timescale 1ns/1ps
module pfd_lock_qual
   import pfd_lock_pkg::*;
#(
   parameter int unsigned LOCK_PERIODS = 16,
   parameter int unsigned CW           = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   input  logic          act,
   input  logic [CW-1:0] limit,
   output logic          locked
);
   localparam int unsigned GW = cnt_bits(LOCK_PERIODS);
   localparam logic [GW-1:0] LAST = GW'(LOCK_PERIODS - 1);

   logic [CW-1:0] act_cnt;
   logic [CW-1:0] width_now;
   logic [GW-1:0] good_cnt;
   logic          bad;

   assign width_now = (act && (act_cnt != '1)) ? act_cnt + CW'(1) : act_cnt;
   assign bad       = width_now > limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cnt  <= '0;
         good_cnt <= '0;
         locked   <= 1'b0;
      end else if (!en) begin
         act_cnt  <= '0;
         good_cnt <= '0;
         locked   <= 1'b0;
      end else if (tick) begin
         act_cnt <= '0;
         if (bad) begin
            good_cnt <= '0;
            locked   <= 1'b0;
         end else begin
            if (good_cnt != GW'(LOCK_PERIODS)) good_cnt <= good_cnt + GW'(1);
            if (good_cnt >= LAST) locked <= 1'b1;
         end
      end else begin
         act_cnt <= width_now;
      end
   end

   p_drop_on_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && bad) |=> !locked);
   p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!locked && good_cnt == '0));
   p_lock_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(good_cnt) >= LAST));
endmodule

// File: rtl/pfd_lock_detector.sv
`timescale 1ns/1ps
module pfd_lock_detector
   import pfd_lock_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 0,
   parameter int unsigned LOCK_PERIODS = 16,
   parameter int unsigned WIDTH_BITS   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fb_in,
   input  logic                  ref_in,
   input  logic                  out_en,
   input  logic [WIDTH_BITS-1:0] width_limit,
   output logic                  up_n,
   output logic                  dn_n,
   output logic                  activity,
   output logic                  locked
);
   generate
      if (LOCK_PERIODS < 2) begin : g_bad_periods
         $error("LOCK_PERIODS must be at least 2");
      end
      if (WIDTH_BITS < 2 || WIDTH_BITS > 16) begin : g_bad_width
         $error("WIDTH_BITS must be 2..16");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic       ref_rise;
   logic       fb_rise;
   pfd_flags_t flags;

   pfd_edge_tap #(.SYNC_STAGES(SYNC_STAGES)) u_ref_tap (
      .clk(clk), .rst_n(rst_n), .sig(ref_in), .rise(ref_rise));
   pfd_edge_tap #(.SYNC_STAGES(SYNC_STAGES)) u_fb_tap (
      .clk(clk), .rst_n(rst_n), .sig(fb_in), .rise(fb_rise));

   pfd_flag_core u_core (
      .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise), .flags(flags));

   assign up_n     = ~(flags.up & out_en);
   assign dn_n     = ~(flags.dn & out_en);
   assign activity = ~(up_n & dn_n);

   pfd_lock_qual #(.LOCK_PERIODS(LOCK_PERIODS), .CW(WIDTH_BITS)) u_qual (
      .clk(clk), .rst_n(rst_n), .en(out_en), .tick(ref_rise),
      .act(activity), .limit(width_limit), .locked(locked));

   p_pair_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_n && !dn_n) |=> (up_n && dn_n));
   p_activity_nand_r5: assert property (@(posedge clk) disable iff (!rst_n)
      activity == !(up_n && dn_n));
endmodule

// File: tb/pfd_lock_detector_tb.sv
`timescale 1ns/1ps
module pfd_lock_detector_tb;
   localparam int PER = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fb_in = 1'b0;
   logic       ref_in = 1'b0;
   logic       out_en = 1'b1;
   logic [7:0] width_limit = 8'd2;
   logic       up_n, dn_n, activity, locked;

   int n_checks = 0;
   int n_fail   = 0;
   int up_lo, dn_lo, act_hi, nand_bad;

   always #5 clk = ~clk;

   pfd_lock_detector u_dut (
      .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .ref_in(ref_in), .out_en(out_en),
      .width_limit(width_limit), .up_n(up_n), .dn_n(dn_n),
      .activity(activity), .locked(locked));

   task automatic chk(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   // One 12-clock period: ref rises at cycle t_ref, feedback at t_fb, each held h clocks.
   task automatic run_period(input int t_ref, input int t_fb, input int h);
      up_lo = 0; dn_lo = 0; act_hi = 0; nand_bad = 0;
      for (int c = 0; c < PER; c++) begin
         @(negedge clk);
         ref_in = (t_ref >= 0) && (c >= t_ref) && (c < t_ref + h);
         fb_in  = (t_fb  >= 0) && (c >= t_fb)  && (c < t_fb + h);
         @(posedge clk);
         #1;
         if (!up_n) up_lo++;
         if (!dn_n) dn_lo++;
         if (activity) act_hi++;
         if (activity != !(up_n && dn_n)) nand_bad++;
      end
   endtask

   task automatic run_aligned(input int n);
      for (int k = 0; k < n; k++) run_period(0, 0, 2);
   endtask

   task automatic t_reset();
      chk("R10 up_n", int'(up_n), 1);
      chk("R10 dn_n", int'(dn_n), 1);
      chk("R10 activity", int'(activity), 0);
      chk("R10 locked", int'(locked), 0);
   endtask

   task automatic t_lock_count();
      run_aligned(15);
      chk("R7 not locked after 15", int'(locked), 0);
      run_aligned(1);
      chk("R7 locked after 16", int'(locked), 1);
   endtask

   task automatic t_lock_drop();
      run_period(0, 5, 2);              // width 6 > limit 2
      run_aligned(1);                   // its evaluation happens here
      chk("R8 dropped", int'(locked), 0);
      run_aligned(15);
      chk("R8 run restarted (15)", int'(locked), 0);
      run_aligned(1);
      chk("R8 relocked (16)", int'(locked), 1);
   endtask

   task automatic t_disable();
      out_en = 1'b0;
      run_period(0, 3, 2);
      chk("R9 up quiet", up_lo, 0);
      chk("R9 dn quiet", dn_lo, 0);
      chk("R9 activity quiet", act_hi, 0);
      chk("R9 locked cleared", int'(locked), 0);
      out_en = 1'b1;
      run_aligned(15);
      chk("R9 count restarted (15)", int'(locked), 0);
      run_aligned(1);
      chk("R9 relocked (16)", int'(locked), 1);
   endtask

   task automatic t_ref_leads();
      run_period(0, 3, 2);
      chk("R1 up low width", up_lo, 4);
      chk("R3 trailing dn width", dn_lo, 1);
      chk("R5 activity width", act_hi, 4);
      chk("R5 nand", nand_bad, 0);
   endtask

   task automatic t_fb_leads();
      run_period(4, 0, 2);
      chk("R2 dn low width", dn_lo, 5);
      chk("R3 trailing up width", up_lo, 1);
      chk("R5 nand", nand_bad, 0);
   endtask

   task automatic t_aligned();
      run_period(2, 2, 2);
      chk("R4 up one clock", up_lo, 1);
      chk("R4 dn one clock", dn_lo, 1);
      chk("R3 aligned activity", act_hi, 1);
   endtask

   task automatic t_falling();
      run_period(1, 1, 8);              // long high, falls inside the period
      chk("R6 up only once", up_lo, 1);
      chk("R6 dn only once", dn_lo, 1);
      run_period(-1, -1, 2);            // inputs stay low
      chk("R6 no pulse idle up", up_lo, 0);
      chk("R6 no pulse idle dn", dn_lo, 0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_lock_count();
      t_lock_drop();
      t_disable();
      t_ref_leads();
      t_fb_leads();
      t_aligned();
      t_falling();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule